// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic 24-bit down-counter that a processor core programs over a simple word-wide read/write bus. Software writes an interval into the reload register, clears the current value, then sets the enable bit in the control/status register. Each tick takes the counter one step closer to zero. When the count passes from one to zero, a sticky flag is set and an interrupt request can pulse. On the next tick the counter refills from the reload register, so an interval of N ticks needs a reload value of N-1.

A control bit selects the tick rate. With that bit set, the counter ticks on every bus clock. With it clear, the counter ticks once in every eight bus clocks, using an enable from a free-running 3-bit prescaler. The whole block uses one clock domain, and the slow rate is a clock-enable, not a derived clock. A loop that waits for the flag can poll the control/status register, because a read of that register clears the flag.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-value registers all read zero, and `irq` is low.
- R2: The bus decodes a 2-bit word index. Index 0 is control/status, index 1 is reload and index 2 is current value. Reads return data in the same cycle. Index 3 reads zero and writes to it are ignored.
- R3: Reload and current value are 24 bits wide. Bits 31..24 of the bus data are dropped on a reload write and read back as zero.
- R4: Control bit 0 is the run enable. While it is clear, the current value holds.
- R5: Control bit 2 selects the tick source. A value of 1 gives one tick per bus clock. A value of 0 gives one tick on every eighth bus clock, so 80 clocks move the counter by exactly 10.
- R6: A control write that changes bit 2 restarts the prescaler at zero. In divide-by-8 mode, the first tick then takes effect on the eighth clock edge after the write edge.
- R7: When the counter is enabled and holds zero, a tick loads the reload value; any other tick decrements it. Consecutive wraps are therefore reload+1 ticks apart. A reload of zero never wraps.
- R8: Control bit 16 is the count flag. It sets when a tick moves the counter from 1 to 0, a read of the control/status register clears it, and a write to bit 16 has no effect.
- R9: Control bit 1 enables the interrupt. With it set, `irq` is high for exactly one cycle, on the same edge that sets the flag. With it clear, `irq` stays low.
- R10: A write of any value to the current-value register sets the counter to zero and clears the flag. This write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| busEn | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The case hardest to reach from the ports is the prescaler restart in divide-by-8 mode, because the prescaler phase cannot be read back. The stimulus first writes the control register with the fast source selected and the counter stopped. It then writes a control value that switches to the slow source and starts counting. After that it reads the current value on the exact cycles before and after the eighth edge, showing that the first load lands there. Wrap periods and pulse widths are measured at `irq` for several reload values in both source modes. The divide-by-8 rate is also checked as a difference between two current-value reads taken exactly 80 clocks apart, so the check does not depend on the prescaler phase.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int CNT_W   = 24;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int PRE_W   = 3;

  localparam int EN_BIT   = 0;
  localparam int IRQ_BIT  = 1;
  localparam int SRC_BIT  = 2;
  localparam int FLAG_BIT = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_NONE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic tick;
    logic clrCount;
    logic loadReload;
  } dpStrobe_t;
endpackage

// File: rtl/tick_datapath.sv
module tick_datapath
  import systick_pkg::*;
#(
  parameter int CNT_WIDTH = CNT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [CNT_WIDTH-1:0] reloadIn,
  output logic [CNT_WIDTH-1:0] cntVal,
  output logic [CNT_WIDTH-1:0] reloadVal,
  output logic                 wrapNow
);
  localparam logic [CNT_WIDTH-1:0] ONE  = CNT_WIDTH'(1);
  localparam logic [CNT_WIDTH-1:0] ZERO = '0;

  logic [CNT_WIDTH-1:0] cntNext;

  assign wrapNow = strobe.tick && !strobe.clrCount && (cntVal == ONE);

  always_comb begin
    cntNext = cntVal;
    if (strobe.clrCount)         cntNext = ZERO;
    else if (strobe.tick) begin
      if (cntVal == ZERO)        cntNext = reloadVal;
      else                       cntNext = cntVal - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal    <= ZERO;
      reloadVal <= ZERO;
    end else begin
      cntVal <= cntNext;
      if (strobe.loadReload) reloadVal <= reloadIn;
    end
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clrCount) |=> $stable(cntVal));

  // R10
  clear_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCount |=> (cntVal == ZERO));

  // R7
  reload_on_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.clrCount && cntVal == ZERO) |=> (cntVal == $past(reloadVal)));
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import systick_pkg::*;
#(
  parameter int CNT_WIDTH  = CNT_W,
  parameter int DATA_WIDTH = DATA_W,
  parameter int PRE_WIDTH  = PRE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busEn,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [SRC_BIT:0]      ctrlBits,
  input  logic [CNT_WIDTH-1:0]  cntVal,
  input  logic [CNT_WIDTH-1:0]  reloadVal,
  input  logic                  wrapNow,
  output dpStrobe_t             strobe,
  output logic [DATA_WIDTH-1:0] busRdata,
  output logic                  irq
);
  localparam logic [PRE_WIDTH-1:0] PRE_LAST = '1;

  logic enBit, irqEnBit, srcFast, flag;
  logic [PRE_WIDTH-1:0] pre;
  logic wrCtrl, wrReload, wrCur, rdCtrl, srcChange, tickRaw;
  regSel_e sel;

  assign sel       = regSel_e'(busAddr);
  assign wrCtrl    = busEn && busWr && (sel == REG_CTRL);
  assign wrReload  = busEn && busWr && (sel == REG_RELOAD);
  assign wrCur     = busEn && busWr && (sel == REG_CURRENT);
  assign rdCtrl    = busEn && !busWr && (sel == REG_CTRL);
  assign srcChange = wrCtrl && (ctrlBits[SRC_BIT] != srcFast);
  assign tickRaw   = srcFast || (pre == PRE_LAST);

  assign strobe.tick       = enBit && tickRaw;
  assign strobe.clrCount   = wrCur;
  assign strobe.loadReload = wrReload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      irqEnBit <= 1'b0;
      srcFast  <= 1'b0;
      pre      <= '0;
      flag     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enBit    <= ctrlBits[EN_BIT];
        irqEnBit <= ctrlBits[IRQ_BIT];
        srcFast  <= ctrlBits[SRC_BIT];
      end
      if (srcChange) pre <= '0;
      else           pre <= pre + PRE_WIDTH'(1);
      if (wrapNow)              flag <= 1'b1;
      else if (wrCur || rdCtrl) flag <= 1'b0;
      irq <= wrapNow && irqEnBit;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (sel)
      REG_CTRL: begin
        busRdata[EN_BIT]   = enBit;
        busRdata[IRQ_BIT]  = irqEnBit;
        busRdata[SRC_BIT]  = srcFast;
        busRdata[FLAG_BIT] = flag;
      end
      REG_RELOAD:  busRdata[CNT_WIDTH-1:0] = reloadVal;
      REG_CURRENT: busRdata[CNT_WIDTH-1:0] = cntVal;
      default:     busRdata = '0;
    endcase
  end

  // R9
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R5
  slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcFast && tickRaw && !srcChange) |=> !tickRaw);

  // R6
  prescale_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcChange |=> (pre == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import systick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  dpStrobe_t         strobe;
  logic [CNT_W-1:0]  cntVal, reloadVal;
  logic              wrapNow;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:CNT_W];

  tick_ctrl #(.CNT_WIDTH(CNT_W), .DATA_WIDTH(DATA_W), .PRE_WIDTH(PRE_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busEn     (busEn),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .ctrlBits  (busWdata[SRC_BIT:0]),
    .cntVal    (cntVal),
    .reloadVal (reloadVal),
    .wrapNow   (wrapNow),
    .strobe    (strobe),
    .busRdata  (busRdata),
    .irq       (irq)
  );

  tick_datapath #(.CNT_WIDTH(CNT_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reloadIn  (busWdata[CNT_W-1:0]),
    .cntVal    (cntVal),
    .reloadVal (reloadVal),
    .wrapNow   (wrapNow)
  );
endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        irq;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  localparam int VEC_N = 6;
  localparam logic        VEC_FAST   [VEC_N] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] VEC_RELOAD [VEC_N] = '{32'd1, 32'd5, 32'd20, 32'd2, 32'd4, 32'd63};
  localparam int          VEC_PERIOD [VEC_N] = '{2, 6, 21, 24, 40, 64};

  always #4 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    busEn = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    busEn = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] a, b;
    bit sawIrq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    busRead(2'd0, a); check("R1 ctrl", a, 32'd0);
    busRead(2'd1, a); check("R1 reload", a, 32'd0);
    busRead(2'd2, a); check("R1 current", a, 32'd0);

    // Table of wrap periods measured at irq (R5 R7 R9)
    for (int v = 0; v < VEC_N; v++) begin
      int n;
      busWrite(2'd0, 32'd0);
      busWrite(2'd1, VEC_RELOAD[v]);
      busWrite(2'd2, 32'd0);
      busWrite(2'd0, {29'd0, VEC_FAST[v], 2'b11});
      n = 0;
      while (!irq && n < 2000) begin @(negedge clk); n++; end
      n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 1) check("R9 pulse width", {31'd0, irq}, 32'd0);
      end while (!irq && n < 2000);
      check("R7 wrap period", n, VEC_PERIOD[v]);
    end
    busWrite(2'd0, 32'd0);

    // R3 upper bits dropped
    busWrite(2'd1, 32'hFFFF_FFFF);
    busRead(2'd1, a); check("R3 reload width", a, 32'h00FF_FFFF);

    // R7 max reload loaded on first tick
    busWrite(2'd0, 32'd4);
    busWrite(2'd2, 32'd0);
    busWrite(2'd0, 32'd5);
    @(negedge clk);
    busRead(2'd2, a); check("R7 first load", a, 32'h00FF_FFFF);

    // R5 fast rate: 80 clocks move the counter by 80
    busRead(2'd2, a);
    repeat (79) @(negedge clk);
    busRead(2'd2, b); check("R5 fast rate", a - b, 32'd80);

    // R4 freeze
    busWrite(2'd0, 32'd4);
    busRead(2'd2, a);
    repeat (20) @(negedge clk);
    busRead(2'd2, b); check("R4 frozen", b, a);

    // R5 slow rate: 80 clocks move the counter by 10
    busWrite(2'd0, 32'd1);
    busRead(2'd2, a);
    repeat (79) @(negedge clk);
    busRead(2'd2, b); check("R5 slow rate", a - b, 32'd10);

    // R10 write clears a running counter at once
    busWrite(2'd2, 32'h1234);
    busRead(2'd2, a); check("R10 clear running", a, 32'd0);

    // R6 prescaler restart on source change
    busWrite(2'd1, 32'd50);
    busWrite(2'd0, 32'd4);
    busWrite(2'd2, 32'd0);
    busWrite(2'd0, 32'd1);
    repeat (7) @(negedge clk);
    busRead(2'd2, a); check("R6 before eighth edge", a, 32'd0);
    busRead(2'd2, a); check("R6 after eighth edge", a, 32'd50);

    // R8 flag set, clear on read; R9 no irq when disabled
    busWrite(2'd1, 32'd3);
    busWrite(2'd2, 32'd0);
    busWrite(2'd0, 32'h0001_0005);
    sawIrq = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq) sawIrq = 1'b1; end
    check("R9 irq disabled", {31'd0, sawIrq}, 32'd0);
    busWrite(2'd0, 32'd4);
    busRead(2'd0, a); check("R8 flag set", a, 32'h0001_0004);
    busRead(2'd0, a); check("R8 flag cleared by read", a, 32'h0000_0004);

    // R10 current write clears flag
    busWrite(2'd0, 32'd5);
    repeat (20) @(negedge clk);
    busWrite(2'd0, 32'd4);
    busWrite(2'd2, 32'hFFFF_FFFF);
    busRead(2'd0, a); check("R10 flag cleared", a, 32'h0000_0004);
    busRead(2'd2, a); check("R10 counter zero", a, 32'd0);

    // R7 reload of zero never wraps
    busWrite(2'd1, 32'd0);
    busWrite(2'd0, 32'd7);
    sawIrq = 1'b0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (irq) sawIrq = 1'b1; end
    check("R7 zero reload no irq", {31'd0, sawIrq}, 32'd0);
    busRead(2'd0, a); check("R7 zero reload no flag", a, 32'h0000_0007);
    busWrite(2'd0, 32'd0);

    // R2 index 3 ignored and reads zero
    busWrite(2'd1, 32'd77);
    busWrite(2'd3, 32'hFFFF_FFFF);
    busRead(2'd1, a); check("R2 reload untouched", a, 32'd77);
    busRead(2'd0, a); check("R2 ctrl untouched", a, 32'd0);
    busRead(2'd3, a); check("R2 index 3 reads zero", a, 32'd0);

    finish();
  end
endmodule